// File: doc/BRIEF.md
# Cascadable I2C Command and Display-Data Decoder

This block sits behind a bit-level I2C receiver in a display driver that can share one bus with identical drivers. The receiver reports START, STOP and each received byte with a one-cycle valid strobe. After each byte it raises an acknowledge request, and the decoder answers whether this device pulls the acknowledge low. The first byte after START is checked against a fixed 6-bit device code and the level of a strap pin. Command bytes then follow, chained by their top bit. Every byte after the last command is display data.

Each command byte produces a one-cycle strobe carrying its 7-bit opcode. Display bytes go to a local RAM write port at a data pointer that advances after every byte. When the pointer passes the last RAM location it wraps to zero and a subaddress counter steps. Every device on the same strap level keeps these counters in step, but only the device whose 3-bit subaddress pins equal the counter writes and acknowledges. Display data therefore flows from one cascaded device to the next. The opcode logic outside this block can load either counter through dedicated load ports.

Top module: `disp_cmd_decoder`

## Requirements
- R1: An address byte whose bits 7:2 equal 011100 and whose bit 1 equals `sa0_i` is acknowledged. `ack_o` equals `ack_req_i` AND the decision for the most recent byte. The decision is taken at that byte's strobe and held until the next byte, START or STOP.
- R2: An address byte that does not match per R1 is not acknowledged. Every later byte of that transfer gives no acknowledge, no command strobe and no RAM write, until the next START.
- R3: A matching address byte with bit 0 (R/W) equal to 1 is acknowledged. Every later byte of that transfer is ignored as in R2.
- R4: A byte in the command phase is acknowledged. It raises `cmd_vld_o` for exactly one cycle, in the cycle after its strobe, with `cmd_op_o` equal to its bits 6:0.
- R5: A command byte with bit 7 equal to 1 makes the next byte a command. With bit 7 equal to 0, every later byte of the transfer is display data.
- R6: A display byte raises `ram_we_o` for one cycle after its strobe, with `ram_addr_o` equal to the data pointer and `ram_wdata_o` equal to the byte. This happens, and the byte is acknowledged, only when the subaddress counter equals `dev_sub_i`. Otherwise there is no write and no acknowledge.
- R7: The data pointer increments by one after every display byte, whether or not this device wrote it.
- R8: A display byte at pointer RAM_DEPTH-1 sets the pointer to 0 and increments the subaddress counter modulo 2^SUB_W.
- R9: STOP returns the decoder to idle, where bytes are ignored as in R2. START at any time, including in the middle of a transfer, restarts address matching.
- R10: `ptr_ld_i` and `sub_ld_i` load their counters from the load values on the next edge. A load takes precedence over an advance in the same cycle.
- R11: After reset both counters are 0, all strobes are low, `ack_o` is low and the decoder is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sa0_i | input | 1 | Strap level compared with address bit 1 |
| dev_sub_i | input | SUB_W | Hardware subaddress of this device |
| start_i | input | 1 | START seen on the bus (one-cycle pulse) |
| stop_i | input | 1 | STOP seen on the bus (one-cycle pulse) |
| byte_vld_i | input | 1 | Received byte valid (one-cycle pulse) |
| byte_i | input | 8 | Received byte |
| ack_req_i | input | 1 | Receiver asks for the acknowledge decision |
| ptr_ld_i | input | 1 | Load the data pointer |
| ptr_ld_val_i | input | PTR_W | Data pointer load value |
| sub_ld_i | input | 1 | Load the subaddress counter |
| sub_ld_val_i | input | SUB_W | Subaddress counter load value |
| ack_o | output | 1 | Drive acknowledge low on the bus |
| cmd_vld_o | output | 1 | Command strobe |
| cmd_op_o | output | 7 | Opcode of the last command |
| ram_we_o | output | 1 | Display RAM write enable |
| ram_addr_o | output | PTR_W | Display RAM write address |
| ram_wdata_o | output | 8 | Display RAM write data |

## Verification
The assertions rely on these conditions:
- START, STOP and the byte strobe never share a cycle.
- A pointer load value never exceeds RAM_DEPTH-1.
- The strap and subaddress pins change only between transfers.

The bench drives every input at the falling edge. It keeps each strobe apart by at least one idle cycle, draws load values below RAM_DEPTH, and changes the pins only after STOP. Random transfers mix matching and non-matching addresses, both R/W values, chains of one to four commands, and data runs long enough to wrap the pointer. Occasional transfers omit STOP and restart with START.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ADDR = 3'd1,
      ST_CMD  = 3'd2,
      ST_DATA = 3'd3,
      ST_SKIP = 3'd4
   } dcd_state_e;
endpackage

// File: rtl/dcd_addr_match.sv
module dcd_addr_match #(
   parameter logic [5:0] ADDR_HI = 6'b011100
) (
   input  logic [7:0] byte_i,
   input  logic       sa0_i,
   output logic       hit_o,
   output logic       rd_o
);
   assign hit_o = (byte_i[7:2] == ADDR_HI) && (byte_i[1] == sa0_i);
   assign rd_o  = byte_i[0];
endmodule

// File: rtl/dcd_ptr.sv
module dcd_ptr #(
   parameter int RAM_DEPTH = 40,
   parameter int SUB_W     = 3,
   localparam int PTR_W    = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   input  logic             ptr_ld_i,
   input  logic [PTR_W-1:0] ptr_ld_val_i,
   input  logic             sub_ld_i,
   input  logic [SUB_W-1:0] sub_ld_val_i,
   output logic [PTR_W-1:0] ptr_o,
   output logic [SUB_W-1:0] sub_o
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(RAM_DEPTH - 1);

   logic [PTR_W-1:0] ptr_q;
   logic [SUB_W-1:0] sub_q;
   logic             at_last;

   if (RAM_DEPTH < 2) begin : g_bad_depth
      $error("dcd_ptr: RAM_DEPTH must be at least 2");
   end
   if (SUB_W < 1 || SUB_W > 8) begin : g_bad_sub
      $error("dcd_ptr: SUB_W must lie in 1..8");
   end

   if (RAM_DEPTH == (1 << PTR_W)) begin : g_wrap_pow2
      assign at_last = &ptr_q;
   end else begin : g_wrap_cmp
      assign at_last = (ptr_q == LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         sub_q <= '0;
      end else begin
         if (ptr_ld_i)
            ptr_q <= ptr_ld_val_i;
         else if (adv_i)
            ptr_q <= at_last ? '0 : ptr_q + PTR_W'(1);
         if (sub_ld_i)
            sub_q <= sub_ld_val_i;
         else if (adv_i && at_last)
            sub_q <= sub_q + SUB_W'(1);
      end
   end

   assign ptr_o = ptr_q;
   assign sub_o = sub_q;

   AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= LAST);                                                          // R8
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !at_last && !ptr_ld_i) |=> (ptr_q == $past(ptr_q) + PTR_W'(1))); // R7
   AST_SUB_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && at_last && !sub_ld_i) |=> (sub_q == $past(sub_q) + SUB_W'(1))); // R8
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_ld_i |=> (ptr_q == $past(ptr_ld_val_i)));                            // R10
endmodule

// File: rtl/dcd_seq.sv
module dcd_seq
   import dcd_pkg::*;
#(
   parameter int RAM_DEPTH = 40,
   parameter int SUB_W     = 3,
   localparam int PTR_W    = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             byte_vld_i,
   input  logic [7:0]       byte_i,
   input  logic             addr_hit_i,
   input  logic             addr_rd_i,
   input  logic [SUB_W-1:0] sub_i,
   input  logic [SUB_W-1:0] dev_sub_i,
   input  logic [PTR_W-1:0] ptr_i,
   output logic             adv_o,
   output logic             ack_pend_o,
   output logic             cmd_vld_o,
   output logic [6:0]       cmd_op_o,
   output logic             ram_we_o,
   output logic [PTR_W-1:0] ram_addr_o,
   output logic [7:0]       ram_wdata_o
);
   dcd_state_e state_q, state_d;
   logic       pend_q, pend_d;
   logic       cmd_d, we_d, sub_hit;

   assign sub_hit = (sub_i == dev_sub_i);

   always_comb begin
      state_d = state_q;
      pend_d  = pend_q;
      cmd_d   = 1'b0;
      we_d    = 1'b0;
      adv_o   = 1'b0;
      if (start_i) begin
         state_d = ST_ADDR;
         pend_d  = 1'b0;
      end else if (stop_i) begin
         state_d = ST_IDLE;
         pend_d  = 1'b0;
      end else if (byte_vld_i) begin
         unique case (state_q)
            ST_ADDR: begin
               pend_d  = addr_hit_i;
               state_d = (addr_hit_i && !addr_rd_i) ? ST_CMD : ST_SKIP;
            end
            ST_CMD: begin
               pend_d  = 1'b1;
               cmd_d   = 1'b1;
               state_d = byte_i[7] ? ST_CMD : ST_DATA;
            end
            ST_DATA: begin
               pend_d = sub_hit;
               we_d   = sub_hit;
               adv_o  = 1'b1;
            end
            default: pend_d = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         pend_q      <= 1'b0;
         cmd_vld_o   <= 1'b0;
         cmd_op_o    <= '0;
         ram_we_o    <= 1'b0;
         ram_addr_o  <= '0;
         ram_wdata_o <= '0;
      end else begin
         state_q   <= state_d;
         pend_q    <= pend_d;
         cmd_vld_o <= cmd_d;
         ram_we_o  <= we_d;
         if (cmd_d)
            cmd_op_o <= byte_i[6:0];
         if (adv_o) begin
            ram_addr_o  <= ptr_i;
            ram_wdata_o <= byte_i;
         end
      end
   end

   assign ack_pend_o = pend_q;

   AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SKIP && byte_vld_i && !start_i && !stop_i)
      |=> (!pend_q && !cmd_vld_o && !ram_we_o));                               // R2
   AST_CMD_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld_o |-> ($past(byte_vld_i) && $past(state_q == ST_CMD)));          // R4
   AST_WE_SUB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we_o |-> ($past(sub_i == dev_sub_i) && $past(state_q == ST_DATA)));  // R6
   AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_vld_o, ram_we_o}));                                        // R5
   AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i) |=> (state_q == ST_IDLE && !pend_q));               // R9
endmodule

// File: rtl/disp_cmd_decoder.sv
module disp_cmd_decoder #(
   parameter int         RAM_DEPTH = 40,
   parameter int         SUB_W     = 3,
   parameter logic [5:0] ADDR_HI   = 6'b011100,
   localparam int        PTR_W     = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sa0_i,
   input  logic [SUB_W-1:0] dev_sub_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             byte_vld_i,
   input  logic [7:0]       byte_i,
   input  logic             ack_req_i,
   input  logic             ptr_ld_i,
   input  logic [PTR_W-1:0] ptr_ld_val_i,
   input  logic             sub_ld_i,
   input  logic [SUB_W-1:0] sub_ld_val_i,
   output logic             ack_o,
   output logic             cmd_vld_o,
   output logic [6:0]       cmd_op_o,
   output logic             ram_we_o,
   output logic [PTR_W-1:0] ram_addr_o,
   output logic [7:0]       ram_wdata_o
);
   logic             hit, rd, adv, pend;
   logic [PTR_W-1:0] ptr;
   logic [SUB_W-1:0] sub;

   dcd_addr_match #(.ADDR_HI(ADDR_HI)) u_match (
      .byte_i(byte_i), .sa0_i(sa0_i), .hit_o(hit), .rd_o(rd));

   dcd_seq #(.RAM_DEPTH(RAM_DEPTH), .SUB_W(SUB_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .byte_vld_i(byte_vld_i), .byte_i(byte_i), .addr_hit_i(hit),
      .addr_rd_i(rd), .sub_i(sub), .dev_sub_i(dev_sub_i), .ptr_i(ptr),
      .adv_o(adv), .ack_pend_o(pend), .cmd_vld_o(cmd_vld_o),
      .cmd_op_o(cmd_op_o), .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o),
      .ram_wdata_o(ram_wdata_o));

   dcd_ptr #(.RAM_DEPTH(RAM_DEPTH), .SUB_W(SUB_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .adv_i(adv), .ptr_ld_i(ptr_ld_i),
      .ptr_ld_val_i(ptr_ld_val_i), .sub_ld_i(sub_ld_i),
      .sub_ld_val_i(sub_ld_val_i), .ptr_o(ptr), .sub_o(sub));

   assign ack_o = ack_req_i & pend;

   AST_ACK_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(byte_vld_i));                                      // R1
endmodule

// File: tb/disp_cmd_decoder_tb_top.sv
module disp_cmd_decoder_tb_top;
   localparam int DEPTH = 40;
   localparam int PW    = $clog2(DEPTH);

   logic clk = 1'b0, rst_n = 1'b0;
   logic sa0 = 1'b0, start = 1'b0, stop = 1'b0, bvld = 1'b0, ackreq = 1'b0;
   logic [2:0] devsub = 3'd0;
   logic [7:0] bdat = '0;
   logic pld = 1'b0, sld = 1'b0;
   logic [PW-1:0] pval = '0;
   logic [2:0] sval = '0;
   logic ack, cvld, we;
   logic [6:0] cop;
   logic [PW-1:0] waddr;
   logic [7:0] wdat;

   always #10 clk = ~clk;

   disp_cmd_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .sa0_i(sa0), .dev_sub_i(devsub),
      .start_i(start), .stop_i(stop), .byte_vld_i(bvld), .byte_i(bdat),
      .ack_req_i(ackreq), .ptr_ld_i(pld), .ptr_ld_val_i(pval),
      .sub_ld_i(sld), .sub_ld_val_i(sval), .ack_o(ack), .cmd_vld_o(cvld),
      .cmd_op_o(cop), .ram_we_o(we), .ram_addr_o(waddr), .ram_wdata_o(wdat));

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   // model: 0 idle, 1 address, 2 command, 3 data, 4 skip
   int m_st = 0, m_ptr = 0, m_sub = 0, last_op = 0;
   string addr_tag = "R7";

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] addr_byte(input bit s, input bit r);
      return {6'b011100, s, r};
   endfunction

   task automatic do_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      m_st = 1;
   endtask

   task automatic do_stop();
      @(negedge clk) stop = 1'b1;
      @(negedge clk) stop = 1'b0;
      m_st = 0;
   endtask

   task automatic send(input logic [7:0] b, input bit lp, input int pv,
                       input bit ls, input int sv);
      bit e_cmd = 0, e_we = 0, e_ack = 0;
      int e_addr = 0;
      string tag;
      case (m_st)
         1: begin
            e_ack = (b[7:2] == 6'b011100) && (b[1] == sa0);
            tag = !e_ack ? "R2" : (b[0] ? "R3" : "R1");
            m_st = (e_ack && !b[0]) ? 2 : 4;
         end
         2: begin
            e_cmd = 1; e_ack = 1; last_op = int'(b[6:0]);
            tag = b[7] ? "R5" : "R4";
            m_st = b[7] ? 2 : 3;
         end
         3: begin
            e_we = (m_sub == int'(devsub)); e_ack = e_we; e_addr = m_ptr;
            tag = "R6";
            if (m_ptr == DEPTH - 1) begin
               m_ptr = 0; m_sub = (m_sub + 1) % 8; addr_tag = "R8";
            end else begin
               m_ptr++; addr_tag = "R7";
            end
         end
         0: tag = "R9";
         default: tag = "R2";
      endcase
      if (lp) begin m_ptr = pv; addr_tag = "R10"; end
      if (ls) m_sub = sv;
      @(negedge clk);
      bvld = 1'b1; bdat = b; pld = lp; pval = PW'(pv); sld = ls; sval = 3'(sv);
      @(negedge clk);
      bvld = 1'b0; pld = 1'b0; sld = 1'b0;
      check(cvld == e_cmd, tag, "cmd strobe", int'(cvld), int'(e_cmd));
      if (e_cmd) check(int'(cop) == last_op, "R4", "opcode", int'(cop), last_op);
      check(we == e_we, tag, "ram write", int'(we), int'(e_we));
      if (e_we) begin
         check(int'(waddr) == e_addr, tag, "ram addr", int'(waddr), e_addr);
         check(wdat == b, "R6", "ram data", int'(wdat), int'(b));
      end
      ackreq = 1'b1;
      #2;
      check(ack == e_ack, tag, "ack", int'(ack), int'(e_ack));
      @(negedge clk) ackreq = 1'b0;
   endtask

   task automatic sendb(input logic [7:0] b);
      send(b, 0, 0, 0, 0);
   endtask

   // Load task: also exercises R10
   task automatic load(input bit lp, input int pv, input bit ls, input int sv);
      @(negedge clk);
      pld = lp; pval = PW'(pv); sld = ls; sval = 3'(sv);
      @(negedge clk);
      pld = 1'b0; sld = 1'b0;
      if (lp) begin m_ptr = pv; addr_tag = "R10"; end
      if (ls) m_sub = sv;
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed = 32'd1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      // R11: reset values
      check(ack == 1'b0 && cvld == 1'b0 && we == 1'b0, "R11", "strobes low",
            int'({ack, cvld, we}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(int'(waddr) == 0, "R11", "addr reset", int'(waddr), 0);
      sendb(8'h55);                      // R11 idle ignores bytes

      // directed: basic chain, R1 R4 R5 R6 R7
      do_start();
      sendb(addr_byte(0, 0));
      sendb(8'h85);
      sendb(8'h12);
      sendb(8'hA1); sendb(8'hA2); sendb(8'hA3);
      do_stop();
      sendb(8'h70);                      // R9 after STOP ignored
      // R2: wrong strap
      do_start();
      sendb(addr_byte(1, 0)); sendb(8'h01); sendb(8'h33);
      do_stop();
      // R3: read transfer
      do_start();
      sendb(addr_byte(0, 1)); sendb(8'h01); sendb(8'h44);
      do_stop();
      // R8: wrap into another device
      load(1, DEPTH - 2, 0, 0);
      do_start();
      sendb(addr_byte(0, 0)); sendb(8'h02);
      sendb(8'h10); sendb(8'h11); sendb(8'h12); sendb(8'h13);
      // R10: load coincides with data advance
      send(8'h14, 1, 5, 1, 0);
      sendb(8'h15);
      // R9: repeated START mid-data
      do_start();
      sendb(addr_byte(0, 0)); sendb(8'h03); sendb(8'h16);
      do_stop();

      // constrained random transfers
      for (int t = 0; t < 300; t++) begin
         sa0 = 1'($urandom_range(0, 1));
         devsub = 3'($urandom_range(0, 7));
         if ($urandom_range(0, 3) == 0)
            load($urandom_range(0, 1), $urandom_range(0, DEPTH - 1),
                 $urandom_range(0, 1), $urandom_range(0, 7));
         do_start();
         begin
            bit s = ($urandom_range(0, 4) == 0) ? ~sa0 : sa0;
            bit r = ($urandom_range(0, 5) == 0);
            logic [7:0] ab = addr_byte(s, r);
            if ($urandom_range(0, 9) == 0) ab[7:2] = 6'($urandom_range(0, 63));
            sendb(ab);
         end
         begin
            int nc = $urandom_range(1, 4);
            for (int c = 0; c < nc; c++)
               sendb({(c != nc - 1), 7'($urandom_range(0, 127))});
         end
         begin
            int nd = $urandom_range(0, 45);
            for (int d = 0; d < nd; d++) begin
               if ($urandom_range(0, 15) == 0)
                  send(8'($urandom), 1, $urandom_range(0, DEPTH - 1),
                       $urandom_range(0, 1), $urandom_range(0, 7));
               else
                  sendb(8'($urandom));
            end
         end
         if ($urandom_range(0, 7) != 0) do_stop();
         else begin m_st = 0; do_start(); do_stop(); end
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule